// File: doc/BRIEF.md
# Warp Issue Scheduler with Register Scoreboard

This block chooses, once per scheduler cycle, at most one instruction from a pool of resident warps and sends it to one of two execution units: a main SIMD ALU and a special-function/interpolator unit (SFU). Each unit stays occupied for several scheduler cycles per accepted instruction. The ALU holds for 2 cycles and the SFU for 8 when warps are 32 lanes wide. With 16-lane groups the figures are 1 and 4. Since the occupancies differ, the scheduler can feed the SFU in the cycle after an ALU issue, from another warp or from the same one. Both units then work at once.

Every warp slot presents its two oldest pending instructions to the block. A per-warp register scoreboard marks the destination of each issued instruction as pending. Write-back tags (warp, register), from ALU results or from loads that may return in any order, clear those marks. The second instruction of a warp may go ahead of a blocked first one when the two are independent, so work continues while loads are outstanding. Among the warps that are ready, a round-robin pointer decides which one issues. Fetch, decode and the datapaths sit outside the block.

Top module: `warp_issue_sched`

## Requirements
- R1: A synchronous active-high reset clears every scoreboard bit, both unit occupancy counters and the round-robin pointer. After reset, a ready warp issues in the first cycle, and warp 0 wins when several warps are ready.
- R2: At most one instruction issues per cycle. `issue_valid` qualifies `issue_warp`, `issue_slot`, `issue_unit` and `issue_dst`. The issued head is always a valid one.
- R3: An ALU issue (`issue_unit`=0) makes the ALU unavailable for the following ALU_OCC-1 cycles. ALU_OCC is 2 for 32-lane warps and 1 for 16-lane groups.
- R4: An SFU issue (`issue_unit`=1) makes the SFU unavailable for the following SFU_OCC-1 cycles. SFU_OCC is 8 for 32-lane warps and 4 for 16-lane groups.
- R5: In a cycle where the ALU is still occupied, a ready SFU instruction issues. It may come from a different warp or from the same warp.
- R6: An instruction issues only when none of its two source registers and its destination register has its scoreboard bit set for its warp.
- R7: Slot 0 is the oldest head and slot 1 the next one. Slot 1 issues only when slot 0 is valid but cannot issue. It also must not read or write slot 0's destination, and must not write either of slot 0's sources.
- R8: A write-back (`wb_valid`, `wb_warp`, `wb_reg`) clears one scoreboard bit, and the change is visible in the next cycle. Returns may arrive in any order, and each one unblocks only the instructions that depend on it.
- R9: The round-robin search starts at the warp after the last one issued, wrapping from the highest warp back to warp 0.
- R10: When no head is both free of hazards and aimed at an available unit, `issue_valid` is 0 and no state other than the occupancy counters changes.
- R11: An issue sets the scoreboard bit of the issued destination in the next cycle. If a write-back and an issue name the same bit in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scheduler clock |
| rst | input | 1 | Synchronous active-high reset |
| head_valid | input | NUM_WARPS x 2 | Head present, per warp and slot (slot 0 oldest) |
| head_unit | input | NUM_WARPS x 2 | Target unit: 0 ALU, 1 SFU |
| head_dst | input | NUM_WARPS x 2 x REG_W | Destination register index |
| head_src0 | input | NUM_WARPS x 2 x REG_W | First source register index |
| head_src1 | input | NUM_WARPS x 2 x REG_W | Second source register index |
| wb_valid | input | 1 | Write-back tag present |
| wb_warp | input | WID_W | Warp of the write-back |
| wb_reg | input | REG_W | Register cleared by the write-back |
| issue_valid | output | 1 | An instruction issues this cycle |
| issue_warp | output | WID_W | Warp of the issued instruction |
| issue_slot | output | 1 | Head slot that issued |
| issue_unit | output | 1 | Unit receiving it: 0 ALU, 1 SFU |
| issue_dst | output | REG_W | Destination marked pending |

## Verification
The bench builds the block with six warp slots, sixteen registers and 32-lane occupancies (ALU 2 cycles, SFU 8). Six slots are few enough that the pointer wrap and the skipping of idle warps show within a handful of cycles. The long SFU window still leaves room to watch an ALU-busy cycle hand the issue slot to the SFU. Out-of-order load returns are shown by clearing two pending registers in reverse order and checking that only the second return unblocks the waiting warp.

// File: rtl/wis_pkg.sv
package wis_pkg;

    typedef enum logic {
        UNIT_ALU = 1'b0,
        UNIT_SFU = 1'b1
    } unit_e;

    localparam int UNIT_COUNT = 2;

    function automatic int alu_occupancy(input bit wide);
        return wide ? 2 : 1;
    endfunction

    function automatic int sfu_occupancy(input bit wide);
        return wide ? 8 : 4;
    endfunction

endpackage

// File: rtl/wis_unit_timer.sv
module wis_unit_timer #(
    parameter int OCC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic free
);
    localparam int CW = (OCC > 1) ? $clog2(OCC) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = CW'(OCC - 1);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign free = (cnt_q == '0);

endmodule

// File: rtl/wis_hazard.sv
module wis_hazard #(
    parameter int NUM_REGS = 16,
    parameter int REG_W    = 4
) (
    input  logic [NUM_REGS-1:0]         pend,
    input  logic [1:0]                  unit_free,
    input  logic [1:0]                  hv,
    input  logic [1:0]                  hu,
    input  logic [1:0][REG_W-1:0]       hd,
    input  logic [1:0][REG_W-1:0]       ha,
    input  logic [1:0][REG_W-1:0]       hb,
    output logic                        ok0,
    output logic                        ok1
);
    logic clear0, clear1, order_dep;

    always_comb begin
        clear0 = !pend[hd[0]] && !pend[ha[0]] && !pend[hb[0]];
        clear1 = !pend[hd[1]] && !pend[ha[1]] && !pend[hb[1]];

        // true, anti and output dependence of the younger head on the older one
        order_dep = (ha[1] == hd[0]) || (hb[1] == hd[0]) || (hd[1] == hd[0])
                 || (hd[1] == ha[0]) || (hd[1] == hb[0]);

        ok0 = hv[0] && unit_free[hu[0]] && clear0;
        ok1 = hv[0] && hv[1] && !ok0 && unit_free[hu[1]] && clear1 && !order_dep;
    end

endmodule

// File: rtl/wis_rr_pick.sv
module wis_rr_pick #(
    parameter int N     = 24,
    parameter int IDX_W = 5
) (
    input  logic [N-1:0]     req,
    input  logic [IDX_W-1:0] start_idx,
    output logic             found,
    output logic [IDX_W-1:0] sel
);
    always_comb begin
        found = 1'b0;
        sel   = '0;
        for (int i = 0; i < N; i++) begin
            int idx;
            idx = int'(start_idx) + i;
            if (idx >= N) idx = idx - N;
            if (!found && req[idx]) begin
                found = 1'b1;
                sel   = IDX_W'(idx);
            end
        end
    end

endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
    import wis_pkg::*;
#(
    parameter int NUM_WARPS = 24,
    parameter int NUM_REGS  = 16,
    parameter bit WIDE_WARP = 1'b1,
    localparam int WID_W    = $clog2(NUM_WARPS),
    localparam int REG_W    = $clog2(NUM_REGS)
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic [NUM_WARPS-1:0][1:0]             head_valid,
    input  logic [NUM_WARPS-1:0][1:0]             head_unit,
    input  logic [NUM_WARPS-1:0][1:0][REG_W-1:0]  head_dst,
    input  logic [NUM_WARPS-1:0][1:0][REG_W-1:0]  head_src0,
    input  logic [NUM_WARPS-1:0][1:0][REG_W-1:0]  head_src1,
    input  logic                                  wb_valid,
    input  logic [WID_W-1:0]                      wb_warp,
    input  logic [REG_W-1:0]                      wb_reg,
    output logic                                  issue_valid,
    output logic [WID_W-1:0]                      issue_warp,
    output logic                                  issue_slot,
    output logic                                  issue_unit,
    output logic [REG_W-1:0]                      issue_dst
);
    localparam int ALU_OCC = alu_occupancy(WIDE_WARP);
    localparam int SFU_OCC = sfu_occupancy(WIDE_WARP);

    typedef struct packed {
        logic [NUM_WARPS-1:0][NUM_REGS-1:0] sb;
        logic [WID_W-1:0]                   ptr;
    } state_t;

    state_t state_d, state_q;

    logic [UNIT_COUNT-1:0] unit_free;
    logic [UNIT_COUNT-1:0] unit_start;
    logic [NUM_WARPS-1:0]  ok0, ok1, warp_req;
    logic                  pick_found;
    logic [WID_W-1:0]      pick_sel;

    // per-unit occupancy timers
    for (genvar u = 0; u < UNIT_COUNT; u++) begin : g_unit
        localparam int OCC = (u == int'(UNIT_ALU)) ? ALU_OCC : SFU_OCC;
        wis_unit_timer #(.OCC(OCC)) u_timer (
            .clk   (clk),
            .rst   (rst),
            .start (unit_start[u]),
            .free  (unit_free[u])
        );
    end

    // per-warp readiness of the two oldest heads
    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
        wis_hazard #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_hz (
            .pend      (state_q.sb[w]),
            .unit_free (unit_free),
            .hv        (head_valid[w]),
            .hu        (head_unit[w]),
            .hd        (head_dst[w]),
            .ha        (head_src0[w]),
            .hb        (head_src1[w]),
            .ok0       (ok0[w]),
            .ok1       (ok1[w])
        );
        assign warp_req[w] = ok0[w] | ok1[w];
    end

    wis_rr_pick #(.N(NUM_WARPS), .IDX_W(WID_W)) u_pick (
        .req       (warp_req),
        .start_idx (state_q.ptr),
        .found     (pick_found),
        .sel       (pick_sel)
    );

    always_comb begin
        issue_valid = pick_found;
        issue_warp  = pick_sel;
        issue_slot  = !ok0[pick_sel];
        issue_unit  = head_unit[pick_sel][issue_slot];
        issue_dst   = head_dst[pick_sel][issue_slot];

        unit_start = '0;
        if (issue_valid) unit_start[issue_unit] = 1'b1;
    end

    always_comb begin
        state_d = state_q;
        if (wb_valid && (int'(wb_warp) < NUM_WARPS)) begin
            state_d.sb[wb_warp][wb_reg] = 1'b0;
        end
        if (issue_valid) begin
            state_d.sb[issue_warp][issue_dst] = 1'b1;
            state_d.ptr = (int'(issue_warp) == NUM_WARPS - 1) ? '0 : issue_warp + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/wis_checker.sv
module wis_checker
    import wis_pkg::*;
#(
    parameter int NUM_WARPS = 24,
    parameter int NUM_REGS  = 16,
    parameter bit WIDE_WARP = 1'b1,
    localparam int WID_W    = $clog2(NUM_WARPS),
    localparam int REG_W    = $clog2(NUM_REGS)
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic [NUM_WARPS-1:0][1:0]             head_valid,
    input  logic [NUM_WARPS-1:0][1:0][REG_W-1:0]  head_dst,
    input  logic [NUM_WARPS-1:0][1:0][REG_W-1:0]  head_src0,
    input  logic [NUM_WARPS-1:0][1:0][REG_W-1:0]  head_src1,
    input  logic                                  wb_valid,
    input  logic [WID_W-1:0]                      wb_warp,
    input  logic [REG_W-1:0]                      wb_reg,
    input  logic                                  issue_valid,
    input  logic [WID_W-1:0]                      issue_warp,
    input  logic                                  issue_slot,
    input  logic                                  issue_unit
);
    localparam int ALU_OCC = alu_occupancy(WIDE_WARP);
    localparam int SFU_OCC = sfu_occupancy(WIDE_WARP);
    localparam int CW      = $clog2(SFU_OCC + 1);

    logic [CW-1:0] alu_left, sfu_left;
    logic [NUM_WARPS-1:0][NUM_REGS-1:0] shadow;

    always_ff @(posedge clk) begin
        if (rst) begin
            alu_left <= '0;
            sfu_left <= '0;
            shadow   <= '0;
        end else begin
            if (issue_valid && !issue_unit) alu_left <= CW'(ALU_OCC - 1);
            else if (alu_left != '0)        alu_left <= alu_left - 1'b1;
            if (issue_valid && issue_unit)  sfu_left <= CW'(SFU_OCC - 1);
            else if (sfu_left != '0)        sfu_left <= sfu_left - 1'b1;
            if (wb_valid && (int'(wb_warp) < NUM_WARPS)) shadow[wb_warp][wb_reg] <= 1'b0;
            if (issue_valid) shadow[issue_warp][head_dst[issue_warp][issue_slot]] <= 1'b1;
        end
    end

    a_r2_issued_head_valid: assert property (@(posedge clk) disable iff (rst)
        issue_valid |-> head_valid[issue_warp][issue_slot]);

    a_r3_alu_not_reused: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && !issue_unit) |-> (alu_left == '0));

    a_r4_sfu_not_reused: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && issue_unit) |-> (sfu_left == '0));

    a_r6_regs_not_pending: assert property (@(posedge clk) disable iff (rst)
        issue_valid |-> (!shadow[issue_warp][head_src0[issue_warp][issue_slot]]
                      && !shadow[issue_warp][head_src1[issue_warp][issue_slot]]
                      && !shadow[issue_warp][head_dst[issue_warp][issue_slot]]));

    a_r7_younger_needs_older: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && issue_slot) |-> head_valid[issue_warp][0]);

endmodule

bind warp_issue_sched wis_checker #(
    .NUM_WARPS (NUM_WARPS),
    .NUM_REGS  (NUM_REGS),
    .WIDE_WARP (WIDE_WARP)
) u_wis_checker (
    .clk         (clk),
    .rst         (rst),
    .head_valid  (head_valid),
    .head_dst    (head_dst),
    .head_src0   (head_src0),
    .head_src1   (head_src1),
    .wb_valid    (wb_valid),
    .wb_warp     (wb_warp),
    .wb_reg      (wb_reg),
    .issue_valid (issue_valid),
    .issue_warp  (issue_warp),
    .issue_slot  (issue_slot),
    .issue_unit  (issue_unit)
);

// File: tb/warp_issue_sched_bench.sv
module warp_issue_sched_bench;
    localparam int NW = 6;
    localparam int NR = 16;
    localparam int WW = $clog2(NW);
    localparam int RW = $clog2(NR);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NW-1:0][1:0]         hv;
    logic [NW-1:0][1:0]         hu;
    logic [NW-1:0][1:0][RW-1:0] hd, ha, hb;
    logic                       wb_valid;
    logic [WW-1:0]              wb_warp;
    logic [RW-1:0]              wb_reg;
    logic                       issue_valid;
    logic [WW-1:0]              issue_warp;
    logic                       issue_slot;
    logic                       issue_unit;
    logic [RW-1:0]              issue_dst;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    warp_issue_sched #(.NUM_WARPS(NW), .NUM_REGS(NR), .WIDE_WARP(1'b1)) u_warp_issue_sched (
        .clk(clk), .rst(rst),
        .head_valid(hv), .head_unit(hu), .head_dst(hd), .head_src0(ha), .head_src1(hb),
        .wb_valid(wb_valid), .wb_warp(wb_warp), .wb_reg(wb_reg),
        .issue_valid(issue_valid), .issue_warp(issue_warp), .issue_slot(issue_slot),
        .issue_unit(issue_unit), .issue_dst(issue_dst)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_h(int w, int s, int unit, int d, int a, int b);
        hv[w][s] = 1'b1;
        hu[w][s] = unit[0];
        hd[w][s] = RW'(d);
        ha[w][s] = RW'(a);
        hb[w][s] = RW'(b);
    endtask

    task automatic clr_h(int w, int s);
        hv[w][s] = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        hv = '0; hu = '0; hd = '0; ha = '0; hb = '0;
        wb_valid = 1'b0; wb_warp = '0; wb_reg = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic send_wb(int w, int r);
        wb_valid = 1'b1;
        wb_warp  = WW'(w);
        wb_reg   = RW'(r);
    endtask

    // v=0 expects no issue; otherwise compares warp, slot and unit too
    task automatic expect_issue(string tag, int v, int w, int s, int u);
        bit bad;
        #1;
        checks++;
        if (v == 0) bad = (issue_valid !== 1'b0);
        else bad = (issue_valid !== 1'b1) || (int'(issue_warp) != w)
                || (int'(issue_slot) != s) || (int'(issue_unit) != u);
        if (bad) begin
            errors++;
            $display("FAIL %s: actual valid=%0b warp=%0d slot=%0d unit=%0d expected valid=%0d warp=%0d slot=%0d unit=%0d",
                     tag, issue_valid, issue_warp, issue_slot, issue_unit, v, w, s, u);
        end
    endtask

    // R1, R3, R9, R10: reset state, ALU occupancy, pointer advance
    task automatic t_alu_rr();
        do_reset();
        expect_issue("R1 idle after reset", 0, 0, 0, 0);
        for (int w = 0; w < NW; w++) set_h(w, 0, 0, 1, 2, 3);
        expect_issue("R1 warp0 first", 1, 0, 0, 0);
        tick(); clr_h(0, 0);
        expect_issue("R3 ALU busy R10 stall", 0, 0, 0, 0);
        tick();
        expect_issue("R9 next warp", 1, 1, 0, 0);
        tick(); clr_h(1, 0);
        expect_issue("R3 ALU busy again", 0, 0, 0, 0);
        tick();
        expect_issue("R9 warp2", 1, 2, 0, 0);
    endtask

    // R2, R5: single issue, SFU fed while ALU busy
    task automatic t_dual_unit();
        do_reset();
        set_h(0, 0, 0, 1, 2, 3);
        set_h(1, 0, 1, 1, 2, 3);
        expect_issue("R2 one issue warp0", 1, 0, 0, 0);
        tick(); clr_h(0, 0);
        expect_issue("R5 SFU other warp", 1, 1, 0, 1);
        do_reset();
        set_h(0, 0, 0, 1, 2, 3);
        set_h(0, 1, 1, 4, 5, 6);
        expect_issue("R5 ALU first same warp", 1, 0, 0, 0);
        tick(); set_h(0, 0, 1, 4, 5, 6); clr_h(0, 1);
        expect_issue("R5 SFU same warp", 1, 0, 0, 1);
    endtask

    // R4, R1: SFU window and reset clearing counters and scoreboard
    task automatic t_sfu_window();
        do_reset();
        set_h(0, 0, 1, 1, 0, 0);
        expect_issue("R4 SFU first", 1, 0, 0, 1);
        tick(); set_h(0, 0, 1, 2, 0, 0);
        for (int k = 1; k < 8; k++) begin
            expect_issue("R4 SFU busy", 0, 0, 0, 0);
            tick();
        end
        expect_issue("R4 SFU free after 8", 1, 0, 0, 1);
        tick(); set_h(0, 0, 1, 3, 0, 0);
        expect_issue("R4 SFU busy after reissue", 0, 0, 0, 0);
        do_reset();
        set_h(0, 0, 1, 5, 2, 1);
        expect_issue("R1 reset cleared SFU and scoreboard", 1, 0, 0, 1);
    endtask

    // R6, R8, R11: pending read and write block, write-back unblocks
    task automatic t_scoreboard();
        do_reset();
        set_h(0, 0, 0, 5, 1, 2);
        expect_issue("R6 clean issue", 1, 0, 0, 0);
        tick(); set_h(0, 0, 0, 6, 5, 0);
        expect_issue("R11 busy and pending", 0, 0, 0, 0);
        tick();
        send_wb(0, 5);
        expect_issue("R11 read of pending reg blocked", 0, 0, 0, 0);
        tick(); wb_valid = 1'b0;
        expect_issue("R8 write-back unblocks", 1, 0, 0, 0);
        tick(); set_h(0, 0, 1, 6, 0, 0);
        expect_issue("R6 pending destination blocks", 0, 0, 0, 0);
    endtask

    // R7, R8: younger head bypass, dependence, out-of-order returns
    task automatic t_second_head();
        do_reset();
        set_h(0, 0, 0, 3, 0, 0);
        expect_issue("R7 setup ALU", 1, 0, 0, 0);
        tick(); set_h(0, 0, 1, 4, 0, 0);
        expect_issue("R7 setup SFU", 1, 0, 0, 1);
        tick();
        set_h(0, 0, 0, 7, 3, 0);
        set_h(0, 1, 0, 8, 9, 10);
        expect_issue("R7 slot1 bypasses blocked slot0", 1, 0, 1, 0);
        tick(); set_h(0, 1, 0, 9, 7, 0);
        expect_issue("R7 ALU busy", 0, 0, 0, 0);
        tick();
        send_wb(0, 4);
        expect_issue("R7 dependent slot1 held", 0, 0, 0, 0);
        tick(); send_wb(0, 3);
        expect_issue("R8 other return does not unblock", 0, 0, 0, 0);
        tick(); wb_valid = 1'b0;
        expect_issue("R8 late return unblocks slot0", 1, 0, 0, 0);
    endtask

    // R9: skip idle warps and wrap
    task automatic t_rr_wrap();
        do_reset();
        set_h(2, 0, 0, 1, 0, 0);
        set_h(4, 0, 0, 1, 0, 0);
        expect_issue("R9 first ready warp2", 1, 2, 0, 0);
        tick(); clr_h(2, 0); set_h(1, 0, 0, 1, 0, 0);
        expect_issue("R9 ALU busy", 0, 0, 0, 0);
        tick();
        expect_issue("R9 warp4 before warp1", 1, 4, 0, 0);
        tick(); clr_h(4, 0);
        expect_issue("R9 ALU busy again", 0, 0, 0, 0);
        tick();
        expect_issue("R9 wrap to warp1", 1, 1, 0, 0);
    endtask

    initial begin
        #(8 * 20000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_alu_rr();
        t_dual_unit();
        t_sfu_window();
        t_scoreboard();
        t_second_head();
        t_rr_wrap();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule